// File: doc/BRIEF.md
# Pipelined Serial Register-Access Slave

This block connects a host to a small file of 16-bit registers over a four-wire serial link. The link runs with the clock idling high, and data is sampled on the rising clock edge. Chip select, serial clock and serial data are brought into the system clock domain through two-flop synchronizers, and all edges are detected on the synchronized copies. A frame is exactly sixteen rising edges with chip select low. A frame either writes one byte of a register or asks for a register word. That word is shifted back on the data-out line during the following frame, while the host sends its next command. Registers are addressed by byte: the even address reaches the low byte and the odd address reaches the upper byte.

The file holds one measurement word per channel, one signed offset per channel, a staging register for an auxiliary DAC level, a status word and a command word. On each sample tick, every channel captures its raw input plus its offset. The tick also raises the channel's new-data flag, and it sets the status bit of any condition input that is high. Reading a measurement word lowers its new-data flag. Reading the status word clears all of its bits. Commands written to the command word can clear the status, copy the staged DAC level to the output, null the offsets against the current measurements, or return the whole file to reset.

Top module: `spireg_slave`

## Requirements
- R1: A frame is acted on only after its sixteenth synchronized rising clock edge with chip select low. If chip select rises after one to fifteen edges, the frame is discarded and writes nothing. Rising edges after the sixteenth are ignored until chip select rises.
- R2: Frame bits are taken MSB first. Bit 15 is the direction (1 = write, 0 = read), bit 14 is ignored, bits 13:8 are the byte address and bits 7:0 are the write data. The data bits of a read frame change no register.
- R3: Byte address 2k+1 reaches the upper byte of the word at 2k, and a write updates that one byte only. The word map is as follows. Channel k's measurement is at 0x00+2k and is read-only. Channel k's 14-bit offset is at 0x10+2k, and its bits 15:14 read 0. The 12-bit DAC staging word is at 0x20. Status is at 0x3C and is read-only. The command word is at 0x3E.
- R4: The word selected by a read frame is shifted out MSB first on `miso` during the next frame, and each bit is valid at the rising clock edge that samples it. After a write frame or a discarded frame, the next frame shifts out 0.
- R5: A measurement word reads as bit 15 = new-data flag, bit 14 = OR of all status bits, and bits 13:0 = value. On a sample tick the value becomes the raw input plus the offset, modulo 2^14.
- R6: A sample tick sets every channel's new-data flag. A read frame of a measurement word clears that channel's flag, and a tick in the same cycle takes precedence.
- R7: Status bit i (i < 2) is set on a sample tick while `cond[i]` is high. Status bit 3 is set when a frame is discarded. A read frame of the status word clears all status bits, and a condition still present sets its bit again on a later tick.
- R8: A write of the command low byte acts on each bit set to 1. Bit 4 clears the status. Bit 2 copies the DAC staging word to `dac_out`. Bit 0 nulls the offsets. The command word always reads 0.
- R9: On a null command, each channel's offset becomes its offset minus its current measurement value (mod 2^14). The next sample with the same raw input therefore reads 0.
- R10: Command bit 7 returns all registers, flags and `dac_out` to 0. It overrides any other command bit written with it.
- R11: `dac_out` changes only through the copy command or a reset. Byte writes to the staging word do not reach it.
- R12: After reset, `miso` and `dac_out` are 0 and every register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial chip select, active low |
| sclk | input | 1 | Serial clock, idles high |
| mosi | input | 1 | Serial data from host |
| miso | output | 1 | Serial data to host |
| sample_tick | input | 1 | One-cycle pulse marking a sample update |
| raw_flat | input | NCH*VAL_W | Raw channel values, channel k at bits [k*VAL_W +: VAL_W] |
| cond | input | NCOND | Condition inputs latched into status on ticks |
| dac_out | output | DAC_W | Latched auxiliary DAC level |

## Verification
A bit-counter that drifts shows up as discarded frames or as replies shifted by one bit on `miso` within a single frame. A wrong flag shows up the next time the host reads the word that carries it: new-data or error bits appear in a measurement reply one frame after the read, and status replies that do not clear or do not re-arm show up one frame later. Offset and DAC staging faults stay hidden until the host reads the register back or issues a copy or null command. For that reason, every command is followed by readbacks and by a check of `dac_out`.

// File: rtl/spireg_pkg.sv
package spireg_pkg;
  localparam int FRAME_BITS = 16;
  localparam int ADDR_W     = 6;
  localparam int WORD_W     = 16;
  localparam int WIDX_W     = ADDR_W - 1;

  // word indices (byte address >> 1)
  localparam logic [WIDX_W-1:0] WI_DATA0 = 5'h00;
  localparam logic [WIDX_W-1:0] WI_OFF0  = 5'h08;
  localparam logic [WIDX_W-1:0] WI_DAC   = 5'h10;
  localparam logic [WIDX_W-1:0] WI_STAT  = 5'h1E;
  localparam logic [WIDX_W-1:0] WI_CMD   = 5'h1F;

  localparam int CMD_RST   = 7;
  localparam int CMD_CLR   = 4;
  localparam int CMD_LATCH = 2;
  localparam int CMD_NULL  = 0;

  localparam int ST_SPI_BIT = 3;
  localparam int ST_W       = ST_SPI_BIT + 1;

  typedef struct packed {
    logic              wr;
    logic [ADDR_W-1:0] addr;
    logic [7:0]        data;
  } req_t;
endpackage

// File: rtl/spireg_rst_sync.sv
module spireg_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= '0;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign srst_n = stage_q[1];
endmodule

// File: rtl/spireg_sync.sv
module spireg_sync #(
  parameter int           W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  assign q = s2_q;
endmodule

// File: rtl/spireg_link.sv
module spireg_link
  import spireg_pkg::*;
#(
  parameter  int FB    = FRAME_BITS,
  localparam int CNT_W = $clog2(FB + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_s,
  input  logic          sclk_s,
  input  logic          mosi_s,
  input  logic [FB-1:0] reply,
  output logic          miso,
  output logic          done,
  output logic          abort,
  output logic [FB-1:0] frame
);
  logic             sclk_d, cs_d;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [FB-1:0]    rx_q, rx_n, tx_q, tx_n;
  logic             done_q, done_n;
  logic             rise, cs_fall, cs_rise, full;

  assign rise    = sclk_s & ~sclk_d & ~cs_s;
  assign cs_fall = ~cs_s & cs_d;
  assign cs_rise = cs_s & ~cs_d;
  assign full    = (cnt_q == CNT_W'(FB));
  assign abort   = cs_rise && (cnt_q != '0) && !full;

  always_comb begin
    cnt_n  = cnt_q;
    rx_n   = rx_q;
    tx_n   = tx_q;
    done_n = 1'b0;
    if (cs_fall) begin
      cnt_n = '0;
    end else if (rise && !full) begin
      cnt_n = cnt_q + 1'b1;
      rx_n  = {rx_q[FB-2:0], mosi_s};
      tx_n  = {tx_q[FB-2:0], 1'b0};
      if (cnt_q == CNT_W'(FB - 1)) done_n = 1'b1;
    end
    if (cs_rise) cnt_n = '0;
    if (done_q)  tx_n  = reply;
    if (abort)   tx_n  = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b1;
      cs_d   <= 1'b1;
      cnt_q  <= '0;
      rx_q   <= '0;
      tx_q   <= '0;
      done_q <= 1'b0;
    end else begin
      sclk_d <= sclk_s;
      cs_d   <= cs_s;
      cnt_q  <= cnt_n;
      rx_q   <= rx_n;
      tx_q   <= tx_n;
      done_q <= done_n;
    end
  end

  assign miso  = tx_q[FB-1];
  assign done  = done_q;
  assign frame = rx_q;
endmodule

// File: rtl/spireg_bank.sv
module spireg_bank
  import spireg_pkg::*;
#(
  parameter  int NCH   = 2,
  parameter  int VAL_W = 14,
  parameter  int DAC_W = 12,
  parameter  int NCOND = 2,
  localparam int HI_V  = VAL_W - 8,
  localparam int HI_D  = DAC_W - 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sample_tick,
  input  logic [NCH*VAL_W-1:0] raw_flat,
  input  logic [NCOND-1:0]     cond,
  input  logic                 frame_done,
  input  logic                 frame_abort,
  input  req_t                 req,
  output logic [WORD_W-1:0]    rd_word,
  output logic [DAC_W-1:0]     dac_out,
  output logic [NCH-1:0]       nd_flags,
  output logic [ST_W-1:0]      st_flags
);
  logic [VAL_W-1:0]  dat_q [NCH];
  logic [VAL_W-1:0]  dat_n [NCH];
  logic [VAL_W-1:0]  off_q [NCH];
  logic [VAL_W-1:0]  off_n [NCH];
  logic [NCH-1:0]    nd_q, nd_n;
  logic [DAC_W-1:0]  dacr_q, dacr_n, dacl_q, dacl_n;
  logic [ST_W-1:0]   st_q, st_n;
  logic [WIDX_W-1:0] widx;
  logic              rd_go, wr_go;
  logic [7:0]        cmd;

  assign widx  = req.addr[ADDR_W-1:1];
  assign rd_go = frame_done & ~req.wr;
  assign wr_go = frame_done & req.wr;
  assign cmd   = (wr_go && widx == WI_CMD && !req.addr[0]) ? req.data : 8'h00;

  // read mux
  always_comb begin
    rd_word = '0;
    if (!req.wr) begin
      for (int k = 0; k < NCH; k++) begin
        if (widx == WI_DATA0 + WIDX_W'(k)) begin
          rd_word     = WORD_W'(dat_q[k]);
          rd_word[15] = nd_q[k];
          rd_word[14] = |st_q;
        end
        if (widx == WI_OFF0 + WIDX_W'(k)) rd_word = WORD_W'(off_q[k]);
      end
      if (widx == WI_DAC)  rd_word = WORD_W'(dacr_q);
      if (widx == WI_STAT) rd_word = WORD_W'(st_q);
    end
  end

  // next state
  always_comb begin
    for (int k = 0; k < NCH; k++) begin
      dat_n[k] = dat_q[k];
      off_n[k] = off_q[k];
    end
    nd_n   = nd_q;
    dacr_n = dacr_q;
    dacl_n = dacl_q;
    st_n   = st_q;

    if (rd_go) begin
      for (int k = 0; k < NCH; k++)
        if (widx == WI_DATA0 + WIDX_W'(k)) nd_n[k] = 1'b0;
      if (widx == WI_STAT) st_n = '0;
    end

    if (wr_go) begin
      for (int k = 0; k < NCH; k++) begin
        if (widx == WI_OFF0 + WIDX_W'(k)) begin
          if (req.addr[0]) off_n[k][VAL_W-1:8] = req.data[HI_V-1:0];
          else             off_n[k][7:0]       = req.data;
        end
      end
      if (widx == WI_DAC) begin
        if (req.addr[0]) dacr_n[DAC_W-1:8] = req.data[HI_D-1:0];
        else             dacr_n[7:0]       = req.data;
      end
    end

    if (cmd[CMD_CLR])   st_n   = '0;
    if (cmd[CMD_LATCH]) dacl_n = dacr_q;
    if (cmd[CMD_NULL]) begin
      for (int k = 0; k < NCH; k++) off_n[k] = off_q[k] - dat_q[k];
    end

    if (frame_abort) st_n[ST_SPI_BIT] = 1'b1;
    if (sample_tick) begin
      for (int k = 0; k < NCH; k++)
        dat_n[k] = raw_flat[k*VAL_W +: VAL_W] + off_q[k];
      nd_n             = '1;
      st_n[NCOND-1:0]  = st_n[NCOND-1:0] | cond;
    end

    if (cmd[CMD_RST]) begin
      for (int k = 0; k < NCH; k++) begin
        dat_n[k] = '0;
        off_n[k] = '0;
      end
      nd_n   = '0;
      dacr_n = '0;
      dacl_n = '0;
      st_n   = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NCH; k++) begin
        dat_q[k] <= '0;
        off_q[k] <= '0;
      end
      nd_q   <= '0;
      dacr_q <= '0;
      dacl_q <= '0;
      st_q   <= '0;
    end else begin
      for (int k = 0; k < NCH; k++) begin
        dat_q[k] <= dat_n[k];
        off_q[k] <= off_n[k];
      end
      nd_q   <= nd_n;
      dacr_q <= dacr_n;
      dacl_q <= dacl_n;
      st_q   <= st_n;
    end
  end

  assign dac_out  = dacl_q;
  assign nd_flags = nd_q;
  assign st_flags = st_q;
endmodule

// File: rtl/spireg_slave.sv
module spireg_slave
  import spireg_pkg::*;
#(
  parameter int NCH   = 2,
  parameter int VAL_W = 14,
  parameter int DAC_W = 12,
  parameter int NCOND = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cs_n,
  input  logic                 sclk,
  input  logic                 mosi,
  output logic                 miso,
  input  logic                 sample_tick,
  input  logic [NCH*VAL_W-1:0] raw_flat,
  input  logic [NCOND-1:0]     cond,
  output logic [DAC_W-1:0]     dac_out
);
  logic                  srst_n;
  logic                  cs_s, sclk_s, mosi_s;
  logic                  frame_done, frame_abort;
  logic [FRAME_BITS-1:0] frame_bits;
  logic [WORD_W-1:0]     rd_word;
  logic [NCH-1:0]        nd_flags;
  logic [ST_W-1:0]       st_flags;
  req_t                  req;

  spireg_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  spireg_sync #(.W(3), .RST_VAL(3'b110)) u_sync (
    .clk   (clk),
    .rst_n (srst_n),
    .d     ({cs_n, sclk, mosi}),
    .q     ({cs_s, sclk_s, mosi_s})
  );

  spireg_link #(.FB(FRAME_BITS)) u_link (
    .clk    (clk),
    .rst_n  (srst_n),
    .cs_s   (cs_s),
    .sclk_s (sclk_s),
    .mosi_s (mosi_s),
    .reply  (rd_word),
    .miso   (miso),
    .done   (frame_done),
    .abort  (frame_abort),
    .frame  (frame_bits)
  );

  assign req.wr   = frame_bits[15];
  assign req.addr = frame_bits[8 +: ADDR_W];
  assign req.data = frame_bits[7:0];

  spireg_bank #(.NCH(NCH), .VAL_W(VAL_W), .DAC_W(DAC_W), .NCOND(NCOND)) u_bank (
    .clk         (clk),
    .rst_n       (srst_n),
    .sample_tick (sample_tick),
    .raw_flat    (raw_flat),
    .cond        (cond),
    .frame_done  (frame_done),
    .frame_abort (frame_abort),
    .req         (req),
    .rd_word     (rd_word),
    .dac_out     (dac_out),
    .nd_flags    (nd_flags),
    .st_flags    (st_flags)
  );
endmodule

// File: rtl/spireg_slave_chk.sv
module spireg_slave_chk
  import spireg_pkg::*;
#(
  parameter int NCH   = 2,
  parameter int DAC_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_s,
  input logic              frame_done,
  input logic              frame_abort,
  input logic              frame_wr,
  input logic [ADDR_W-1:0] frame_addr,
  input logic [7:0]        frame_data,
  input logic              sample_tick,
  input logic [DAC_W-1:0]  dac_out,
  input logic [NCH-1:0]    nd_flags,
  input logic [ST_W-1:0]   st_flags,
  input logic [WORD_W-1:0] rd_word
);
  logic cmd_hit, rst_cmd, touch_dac;

  assign cmd_hit   = frame_done && frame_wr && frame_addr == 6'h3E;
  assign rst_cmd   = cmd_hit && frame_data[CMD_RST];
  assign touch_dac = cmd_hit && (frame_data[CMD_LATCH] || frame_data[CMD_RST]);

  p_one_event_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_done && frame_abort));

  p_abort_edge_r1: assert property (@(posedge clk) disable iff (!rst_n)
    frame_abort |-> (cs_s && !$past(cs_s)));

  p_nd_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_tick && !rst_cmd) |=> (&nd_flags));

  p_spi_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_abort |=> st_flags[ST_SPI_BIT]);

  p_cmd_reads_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !frame_wr && frame_addr[ADDR_W-1:1] == WI_CMD) |-> (rd_word == '0));

  p_soft_reset_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rst_cmd |=> (dac_out == '0 && nd_flags == '0 && st_flags == '0));

  p_dac_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !touch_dac |=> $stable(dac_out));
endmodule

bind spireg_slave spireg_slave_chk #(.NCH(NCH), .DAC_W(DAC_W)) u_chk (
  .clk         (clk),
  .rst_n       (srst_n),
  .cs_s        (cs_s),
  .frame_done  (frame_done),
  .frame_abort (frame_abort),
  .frame_wr    (req.wr),
  .frame_addr  (req.addr),
  .frame_data  (req.data),
  .sample_tick (sample_tick),
  .dac_out     (dac_out),
  .nd_flags    (nd_flags),
  .st_flags    (st_flags),
  .rd_word     (rd_word)
);

// File: tb/spireg_slave_bench.sv
module spireg_slave_bench;
  localparam int NCH   = 2;
  localparam int VAL_W = 14;
  localparam int DAC_W = 12;
  localparam int NCOND = 2;
  localparam int HALF  = 8;
  localparam int NTBL  = 11;

  // {wr, addr, data, expected miso word of this frame}
  localparam logic [30:0] TBL [NTBL] = '{
    {1'b1, 6'h10, 8'h34, 16'h0000},  // first frame after reset shifts 0
    {1'b1, 6'h11, 8'hFF, 16'h0000},  // upper byte: only bits 13:8 kept
    {1'b0, 6'h10, 8'h00, 16'h0000},  // previous frame was a write
    {1'b0, 6'h11, 8'h00, 16'h3F34},  // offset word, bits 15:14 zero
    {1'b1, 6'h20, 8'hAB, 16'h3F34},  // odd address read gives the same word
    {1'b1, 6'h21, 8'hFC, 16'h0000},
    {1'b0, 6'h20, 8'h55, 16'h0000},  // read data bits must not write
    {1'b0, 6'h3E, 8'h00, 16'h0CAB},
    {1'b0, 6'h00, 8'h00, 16'h0000},  // command word reads 0
    {1'b0, 6'h3C, 8'h00, 16'h0000},  // measurement before any tick
    {1'b0, 6'h3C, 8'h00, 16'h0000}   // status after reset
  };

  logic                 clk = 1'b0;
  logic                 rst_n, cs_n, sclk, mosi, sample_tick;
  logic                 miso;
  logic [NCH*VAL_W-1:0] raw_flat;
  logic [NCOND-1:0]     cond;
  logic [DAC_W-1:0]     dac_out;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  spireg_slave #(.NCH(NCH), .VAL_W(VAL_W), .DAC_W(DAC_W), .NCOND(NCOND)) u_spireg_slave (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_n        (cs_n),
    .sclk        (sclk),
    .mosi        (mosi),
    .miso        (miso),
    .sample_tick (sample_tick),
    .raw_flat    (raw_flat),
    .cond        (cond),
    .dac_out     (dac_out)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_h();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic xfer(input logic [15:0] w, input int nb, output logic [15:0] r);
    r    = '0;
    cs_n = 1'b0;
    wait_h();
    for (int i = 15; i >= 16 - nb; i--) begin
      sclk = 1'b0;
      mosi = w[i];
      wait_h();
      r[i] = miso;
      sclk = 1'b1;
      wait_h();
    end
    wait_h();
    cs_n = 1'b1;
    repeat (2) wait_h();
  endtask

  task automatic fr(input logic wr, input logic [5:0] a, input logic [7:0] d,
                    output logic [15:0] got);
    xfer({wr, 1'b0, a, d}, 16, got);
  endtask

  task automatic tick();
    @(negedge clk) sample_tick = 1'b1;
    @(negedge clk) sample_tick = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] g;
    rst_n       = 1'b0;
    cs_n        = 1'b1;
    sclk        = 1'b1;
    mosi        = 1'b0;
    sample_tick = 1'b0;
    cond        = '0;
    raw_flat    = {14'h3F00, 14'h0123};
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R12 reset state
    chk("R12 miso", {15'b0, miso}, 16'h0000);
    chk("R12 dac_out", {4'b0, dac_out}, 16'h0000);

    // R2 R3 R4 table walk
    for (int i = 0; i < NTBL; i++) begin
      fr(TBL[i][30], TBL[i][29:24], TBL[i][23:16], g);
      checks++;
      if (g !== TBL[i][15:0]) begin
        errors++;
        $display("FAIL R4/R3 entry %0d actual=%h expected=%h", i, g, TBL[i][15:0]);
      end
    end

    // R11 staged byte writes do not reach the output
    chk("R11 dac not latched", {4'b0, dac_out}, 16'h0000);
    fr(1'b1, 6'h3E, 8'h04, g);
    chk("R8 latch copies staging", {4'b0, dac_out}, 16'h0CAB);

    // R5 R6 measurement words and new-data flag
    tick();
    fr(1'b0, 6'h00, 8'h00, g);
    fr(1'b0, 6'h02, 8'h00, g);
    chk("R5 ch0 word after tick", g, 16'h8057);
    fr(1'b0, 6'h00, 8'h00, g);
    chk("R5 ch1 word after tick", g, 16'hBF00);
    fr(1'b0, 6'h3C, 8'h00, g);
    chk("R6 ch0 new-data cleared by read", g, 16'h0057);
    fr(1'b0, 6'h00, 8'h00, g);
    chk("R7 status idle", g, 16'h0000);

    // R9 null command
    fr(1'b1, 6'h3E, 8'h01, g);
    fr(1'b0, 6'h10, 8'h00, g);
    fr(1'b0, 6'h12, 8'h00, g);
    chk("R9 ch0 offset after null", g, 16'h3EDD);
    fr(1'b0, 6'h00, 8'h00, g);
    chk("R9 ch1 offset after null", g, 16'h0100);
    tick();
    fr(1'b0, 6'h02, 8'h00, g);
    chk("R5 ch0 captured before tick", g, 16'h0057);
    fr(1'b0, 6'h3C, 8'h00, g);
    chk("R9 ch1 nulled sample", g, 16'h8000);

    // R7 R5 status flags and error bit
    cond = 2'b01;
    tick();
    cond = 2'b00;
    fr(1'b0, 6'h00, 8'h00, g);
    fr(1'b0, 6'h3C, 8'h00, g);
    chk("R5 error bit in measurement", g, 16'hC000);
    fr(1'b0, 6'h3C, 8'h00, g);
    chk("R7 condition latched", g, 16'h0001);
    fr(1'b0, 6'h00, 8'h00, g);
    chk("R7 clear on read", g, 16'h0000);
    fr(1'b0, 6'h3C, 8'h00, g);
    chk("R6 R5 flags after reads", g, 16'h0000);

    // R7 persisting condition sets again
    cond = 2'b10;
    tick();
    fr(1'b0, 6'h3C, 8'h00, g);
    tick();
    fr(1'b0, 6'h3C, 8'h00, g);
    chk("R7 first read", g, 16'h0002);
    cond = 2'b00;
    fr(1'b0, 6'h3C, 8'h00, g);
    chk("R7 set again by tick", g, 16'h0002);
    fr(1'b0, 6'h3C, 8'h00, g);
    chk("R7 cleared when gone", g, 16'h0000);

    // R1 R4 discarded frame
    fr(1'b0, 6'h20, 8'h00, g);
    xfer({1'b1, 1'b0, 6'h20, 8'h00}, 5, g);
    fr(1'b0, 6'h3C, 8'h00, g);
    chk("R4 reply zero after discard", g, 16'h0000);
    fr(1'b0, 6'h20, 8'h00, g);
    chk("R7 link error bit", g, 16'h0008);
    fr(1'b0, 6'h3C, 8'h00, g);
    chk("R1 discarded frame wrote nothing", g, 16'h0CAB);

    // R8 clear-status command
    xfer({1'b1, 1'b0, 6'h20, 8'h00}, 9, g);
    fr(1'b1, 6'h3E, 8'h10, g);
    fr(1'b0, 6'h3C, 8'h00, g);
    fr(1'b0, 6'h00, 8'h00, g);
    chk("R8 clear status", g, 16'h0000);

    // R10 software reset beats latch
    fr(1'b1, 6'h3E, 8'h84, g);
    chk("R10 dac_out reset", {4'b0, dac_out}, 16'h0000);
    fr(1'b0, 6'h10, 8'h00, g);
    fr(1'b0, 6'h20, 8'h00, g);
    chk("R10 offset reset", g, 16'h0000);
    fr(1'b0, 6'h00, 8'h00, g);
    chk("R10 staging reset", g, 16'h0000);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule